// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a simple in-order core and picks the counter's next value on every clock edge. The decoder hands it a control kind for the current instruction, a condition selector, a 16-bit branch offset, a 26-bit jump index and two register operands. The unit resolves compare-and-branch conditions itself and computes the target without a separate flag register. It also offers a return address for the link-writing instructions.

Targets come from three fixed formulas. A branch is relative to the address of the following instruction, and its offset counts words. A region jump keeps the four top counter bits and fills the rest from the index. A register jump takes the whole address from the first operand. A chosen target whose two low bits are not zero raises a misalignment flag, and the counter then keeps its value.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` loads the parameter `RESET_PC` (default 32'h0040_0000).
- R2: When `kind` is 0 (sequential), 6 or 7 (unused codes, treated as sequential), `pc` advances by 4 at the next edge and `taken` is 0.
- R3: When `kind` is 1 (branch) and the condition holds, the next `pc` is pc+4 plus the sign-extended `disp` shifted left by two.
- R4: Branch condition codes 0 and 1 test `opa == opb` and `opa != opb`. A branch whose condition fails advances `pc` by 4.
- R5: Branch condition codes 2 to 7 test signed `opa` against zero: 2 for `<= 0`, 3 for `> 0`, 4 and 6 for `< 0`, 5 and 7 for `>= 0`.
- R6: When `kind` is 2 (jump) or 3 (jump and link), the next `pc` is the top 4 bits of the current `pc`, followed by `jidx`, followed by two zero bits.
- R7: When `kind` is 4 (register jump) or 5 (register jump and link) and the target is aligned, the next `pc` equals `opa`.
- R8: `link_we` is 1 for `kind` 3 or 5, and for `kind` 1 with condition 6 or 7, whether or not that branch is taken. `link_addr` is then pc+4.
- R9: When the chosen target has non-zero low two bits, `misalign` is 1 in the same cycle and `pc` keeps its value at the next edge.
- R10: `taken` is 1 exactly when a jump kind is presented, or when a branch kind is presented and its condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| kind | input | 3 | Control kind of the current instruction |
| cond_sel | input | 3 | Branch condition selector |
| disp | input | 16 | Branch word offset |
| jidx | input | 26 | Region jump index |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| taken | output | 1 | Control transfer chosen this cycle |
| link_we | output | 1 | Return address must be written |
| link_addr | output | 32 | Return address |
| misalign | output | 1 | Chosen target is not word aligned |

## Verification
The counter is the block's only state. A wrong value shows on `pc` one edge after the fault, and it also shows at once through `link_addr` and through every relative target that follows. A wrong condition or target shows on `taken` in the same cycle, and on `pc` one cycle later. The bench keeps its own copy of the expected counter and compares it after every edge, so an error stays visible after it first appears. A misaligned register jump must leave `pc` unchanged, and each such check shows whether the hold worked.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // control kinds presented by the decoder
  localparam logic [2:0] K_SEQ        = 3'd0;
  localparam logic [2:0] K_BRANCH     = 3'd1;
  localparam logic [2:0] K_JUMP       = 3'd2;
  localparam logic [2:0] K_JUMP_LINK  = 3'd3;
  localparam logic [2:0] K_JREG       = 3'd4;
  localparam logic [2:0] K_JREG_LINK  = 3'd5;

  // branch conditions
  localparam logic [2:0] C_EQ        = 3'd0;
  localparam logic [2:0] C_NE        = 3'd1;
  localparam logic [2:0] C_LEZ       = 3'd2;
  localparam logic [2:0] C_GTZ       = 3'd3;
  localparam logic [2:0] C_LTZ       = 3'd4;
  localparam logic [2:0] C_GEZ       = 3'd5;
  localparam logic [2:0] C_LTZ_LINK  = 3'd6;
  localparam logic [2:0] C_GEZ_LINK  = 3'd7;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_REGION = 2'd2,
    SRC_REG    = 2'd3
  } src_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int W = 32
) (
  input  logic [2:0]   cond_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         cond_true
);
  import npc_pkg::*;

  logic a_neg, a_zero, a_eq_b;

  assign a_neg  = opa[W-1];
  assign a_zero = (opa == '0);
  assign a_eq_b = (opa == opb);

  always_comb begin
    unique case (cond_sel)
      C_EQ:                    cond_true = a_eq_b;
      C_NE:                    cond_true = !a_eq_b;
      C_LEZ:                   cond_true = a_neg || a_zero;
      C_GTZ:                   cond_true = !a_neg && !a_zero;
      C_LTZ, C_LTZ_LINK:       cond_true = a_neg;
      default:                 cond_true = !a_neg;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 26
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [2:0]        kind,
  input  logic              cond_true,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  jidx,
  input  logic [ADDR_W-1:0] opa,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] target,
  output logic              taken
);
  import npc_pkg::*;

  localparam int REGION_W = ADDR_W - IDX_W - 2;
  localparam int EXT_W    = ADDR_W - DISP_W - 2;

  function automatic logic [ADDR_W-1:0] f_branch(input logic [ADDR_W-1:0] base,
                                                 input logic [DISP_W-1:0] d);
    return base + {{EXT_W{d[DISP_W-1]}}, d, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] f_region(input logic [ADDR_W-1:0] cur,
                                                 input logic [IDX_W-1:0] idx);
    return {cur[ADDR_W-1 -: REGION_W], idx, 2'b00};
  endfunction

  src_e src;

  assign seq_pc = pc + ADDR_W'(4);

  always_comb begin
    unique case (kind)
      K_BRANCH:               src = cond_true ? SRC_BRANCH : SRC_SEQ;
      K_JUMP, K_JUMP_LINK:    src = SRC_REGION;
      K_JREG, K_JREG_LINK:    src = SRC_REG;
      default:                src = SRC_SEQ;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_BRANCH: target = f_branch(seq_pc, disp);
      SRC_REGION: target = f_region(pc, jidx);
      SRC_REG:    target = opa;
      default:    target = seq_pc;
    endcase
  end

  assign taken = (src != SRC_SEQ);
endmodule

// File: rtl/npc_link.sv
module npc_link #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        kind,
  input  logic [2:0]        cond_sel,
  input  logic [ADDR_W-1:0] seq_pc,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_addr
);
  import npc_pkg::*;

  logic br_link;

  assign br_link   = (kind == K_BRANCH) &&
                     ((cond_sel == C_LTZ_LINK) || (cond_sel == C_GEZ_LINK));
  assign link_we   = br_link || (kind == K_JUMP_LINK) || (kind == K_JREG_LINK);
  assign link_addr = seq_pc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          ADDR_W   = 32,
  parameter int          DISP_W   = 16,
  parameter int          IDX_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        kind,
  input  logic [2:0]        cond_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  jidx,
  input  logic [ADDR_W-1:0] opa,
  input  logic [ADDR_W-1:0] opb,
  output logic [ADDR_W-1:0] pc,
  output logic              taken,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_addr,
  output logic              misalign
);
  import npc_pkg::*;

  localparam int                REGION_W = ADDR_W - IDX_W - 2;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(4);

  logic              cond_true;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] target;
  logic              jump_kind;
  logic              jreg_kind;

  npc_cond #(.W(ADDR_W)) u_cond (
    .cond_sel (cond_sel),
    .opa      (opa),
    .opb      (opb),
    .cond_true(cond_true)
  );

  npc_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_target (
    .pc       (pc),
    .kind     (kind),
    .cond_true(cond_true),
    .disp     (disp),
    .jidx     (jidx),
    .opa      (opa),
    .seq_pc   (seq_pc),
    .target   (target),
    .taken    (taken)
  );

  npc_link #(.ADDR_W(ADDR_W)) u_link (
    .kind     (kind),
    .cond_sel (cond_sel),
    .seq_pc   (seq_pc),
    .link_we  (link_we),
    .link_addr(link_addr)
  );

  assign misalign  = taken && (target[1:0] != 2'b00);
  assign jump_kind = (kind == K_JUMP) || (kind == K_JUMP_LINK);
  assign jreg_kind = (kind == K_JREG) || (kind == K_JREG_LINK);

  always_ff @(posedge clk) begin
    if (rst)            pc <= RESET_PC[ADDR_W-1:0];
    else if (!misalign) pc <= target;
  end

  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (rst)
    !taken |=> pc == $past(pc) + STEP);  // R4
  AST_SEQ_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (kind == K_SEQ) |-> !taken);  // R2
  AST_HOLD_ON_MISALIGN: assert property (@(posedge clk) disable iff (rst)
    misalign |=> $stable(pc));  // R9
  AST_REGION_KEPT: assert property (@(posedge clk) disable iff (rst)
    jump_kind |=> pc[ADDR_W-1 -: REGION_W] == $past(pc[ADDR_W-1 -: REGION_W]));  // R6
  AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (jreg_kind && !misalign) |=> pc == $past(opa));  // R7
  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);  // R9
  AST_LINK_ON_JUMP: assert property (@(posedge clk) disable iff (rst)
    (kind == K_JUMP_LINK || kind == K_JREG_LINK) |-> link_we && taken);  // R8
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_VAL    = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  kind, cond_sel;
  logic [15:0] disp;
  logic [25:0] jidx;
  logic [31:0] opa, opb;
  logic [31:0] pc, link_addr;
  logic        taken, link_we, misalign;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_pc;

  npc_unit uut (
    .clk(clk), .rst(rst), .kind(kind), .cond_sel(cond_sel), .disp(disp),
    .jidx(jidx), .opa(opa), .opb(opb), .pc(pc), .taken(taken),
    .link_we(link_we), .link_addr(link_addr), .misalign(misalign)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic model_cond(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) <= 0;
      3'd3: return $signed(a) > 0;
      3'd4, 3'd6: return $signed(a) < 0;
      default: return $signed(a) >= 0;
    endcase
  endfunction

  // one instruction: drive, check same-cycle outputs, clock, check pc
  task automatic issue(input string tag, input logic [2:0] k, input logic [2:0] c,
                       input logic [15:0] d, input logic [25:0] j,
                       input logic [31:0] a, input logic [31:0] b);
    logic        e_tk, e_lw, e_mis;
    logic [31:0] e_tgt, nxt;
    kind = k; cond_sel = c; disp = d; jidx = j; opa = a; opb = b;
    nxt = exp_pc + 32'd4;
    e_tk = 1'b0; e_tgt = nxt;
    case (k)
      3'd1: if (model_cond(c, a, b)) begin
              e_tk = 1'b1;
              e_tgt = nxt + ({{16{d[15]}}, d} << 2);
            end
      3'd2, 3'd3: begin e_tk = 1'b1; e_tgt = (exp_pc & 32'hF000_0000) | ({6'd0, j} << 2); end
      3'd4, 3'd5: begin e_tk = 1'b1; e_tgt = a; end
      default: ;
    endcase
    e_lw  = (k == 3'd3) || (k == 3'd5) || (k == 3'd1 && (c == 3'd6 || c == 3'd7));
    e_mis = e_tk && (e_tgt[1:0] != 2'b00);
    #1;
    check({tag, " R10 taken"}, {31'd0, taken}, {31'd0, e_tk});
    check({tag, " R8 link_we"}, {31'd0, link_we}, {31'd0, e_lw});
    if (e_lw) check({tag, " R8 link_addr"}, link_addr, nxt);
    check({tag, " R9 misalign"}, {31'd0, misalign}, {31'd0, e_mis});
    @(posedge clk); #1;
    if (!e_mis) exp_pc = e_tgt;
    check({tag, " pc"}, pc, exp_pc);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0;
    exp_pc = RST_VAL;
    check("R1 reset pc", pc, RST_VAL);
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 3; i++) issue("R2 seq", 3'd0, 3'd0, 16'h7FFF, 26'h3, 32'h5, 32'h5);
    issue("R2 unused6", 3'd6, 3'd1, 16'h0010, 26'h0, 32'h0, 32'h0);
    issue("R2 unused7", 3'd7, 3'd0, 16'h0010, 26'h0, 32'h0, 32'h0);
  endtask

  task automatic t_eq_ne();
    issue("R3 R4 beq taken fwd", 3'd1, 3'd0, 16'h0010, 26'h0, 32'h1234, 32'h1234);
    issue("R4 beq not taken", 3'd1, 3'd0, 16'h0010, 26'h0, 32'h1234, 32'h1235);
    issue("R3 R4 bne taken back", 3'd1, 3'd1, 16'hFFFE, 26'h0, 32'h1, 32'h2);
    issue("R4 bne not taken", 3'd1, 3'd1, 16'h8000, 26'h0, 32'h9, 32'h9);
  endtask

  task automatic t_zero_compare();
    logic [31:0] vals [4];
    vals[0] = 32'h8000_0000; vals[1] = 32'h0; vals[2] = 32'h1; vals[3] = 32'hFFFF_FFFF;
    for (int c = 2; c < 8; c++)
      for (int v = 0; v < 4; v++)
        issue("R5 zero cmp", 3'd1, 3'(c), 16'h0004, 26'h0, vals[v], 32'h0);
  endtask

  task automatic t_register_jump();
    issue("R7 jr", 3'd4, 3'd0, 16'h0, 26'h0, 32'hA000_0100, 32'h0);
    issue("R7 R8 jalr", 3'd5, 3'd0, 16'h0, 26'h0, 32'hA000_0200, 32'h0);
  endtask

  task automatic t_region_jump();
    issue("R6 j", 3'd2, 3'd0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0);
    issue("R6 R8 jal", 3'd3, 3'd0, 16'h0, 26'h000_0040, 32'h0, 32'h0);
  endtask

  task automatic t_link_branch();
    issue("R8 ltz link not taken", 3'd1, 3'd6, 16'h0020, 26'h0, 32'h5, 32'h0);
    issue("R8 gez link taken", 3'd1, 3'd7, 16'h0020, 26'h0, 32'h5, 32'h0);
  endtask

  task automatic t_misalign();
    issue("R9 jr low bits 2", 3'd4, 3'd0, 16'h0, 26'h0, 32'h0000_1002, 32'h0);
    issue("R9 jalr low bits 1", 3'd5, 3'd0, 16'h0, 26'h0, 32'h0000_2001, 32'h0);
    issue("R9 after hold seq", 3'd0, 3'd0, 16'h0, 26'h0, 32'h0, 32'h0);
  endtask

  initial begin
    kind = 3'd0; cond_sel = 3'd0; disp = '0; jidx = '0; opa = '0; opb = '0;
    exp_pc = RST_VAL;
    t_reset();
    t_sequential();
    t_eq_ne();
    t_zero_compare();
    t_register_jump();
    t_region_jump();
    t_link_branch();
    t_misalign();
    t_reset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule